// File: doc/BRIEF.md
# Capture/Compare/PWM Unit

This unit sits beside two free-running timers that it does not own. One is a 16-bit counter and the other is an 8-bit period counter with a 2-bit prescaler phase. A small byte-wide write port sets the mode and fills one 16-bit value register, and the unit uses that register differently in each mode.

In capture mode, the register is loaded with the 16-bit timer when a chosen edge arrives on the input pin. The edge can be every falling edge, every rising edge, or one rising edge in four or in sixteen. In compare mode, the register is matched against the 16-bit timer, and a match can drive the output pin. In PWM mode, the low byte of the register and two extra bits give a 10-bit duty. That duty is compared against the period counter joined with its prescaler phase. Captures and matches set a sticky interrupt flag.

Register map: address 0 is control, addresses 1 and 2 are the low and high bytes of the value register, and address 3 holds the flag in bit 0. The control byte is laid out as follows:
- bits [1:0] select the mode: 0 off, 1 capture, 2 compare, 3 PWM.
- bits [3:2] are the sub-select. In capture mode: 0 falling, 1 rising, 2 every 4th rising, 3 every 16th rising. In compare mode: 0 or 3 leaves the pin alone, 1 drives it high, 2 drives it low.
- bits [5:4] are the two low duty bits.

Top module: `ccp_unit`

## Requirements
- R1: While reset is held, and on the cycle after it, the value register, the flag and the output pin read zero. The control byte also resets to zero, which is off mode.
- R2: A write to address 1 loads value bits [7:0], and a write to address 2 loads bits [15:8]. Each is visible on `val_o` one cycle after the write cycle.
- R3: In capture mode with sub-select 0 or 1, a falling or rising transition of `cap_pin` (compared against its value on the previous cycle) loads the timer value presented on that cycle into the value register. The transition of the other polarity loads nothing.
- R4: With sub-select 2 or 3, only every 4th or every 16th rising transition loads the timer value. The transitions in between load nothing.
- R5: A control write that changes bits [3:0] restarts the rising-edge count at zero, and no capture takes place on that write cycle.
- R6: In compare mode, when the timer equals the value register, the output pin is driven on the next cycle according to the action field. Action 1 drives it high, action 2 drives it low, and actions 0 and 3 leave it unchanged.
- R7: A capture or a compare match sets the flag on the next cycle. A write to address 3 loads bit 0 of the write data into the flag. If an event and a flag write fall on the same cycle, the event wins.
- R8: In PWM mode, a period starts on the cycle with `per_start` high. The pin goes high after that cycle if the duty is nonzero. It goes low after the cycle on which {`per_cnt`, `per_phase`} equals the duty, so the pin stays high for duty ticks.
- R9: A duty of zero keeps the pin low for the whole period.
- R10: The duty comes from value bits [7:0] and control bits [5:4]. A new duty is taken only at a period start. A write in mid-period does not change the current period.
- R11: A duty at or above the period length, (period register + 1) × 4 ticks, holds the pin high for the whole period.
- R12: In off mode and in capture mode, the output pin is driven low from the cycle after the mode takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 and 2 value bytes, 3 flag) |
| wr_data | input | 8 | Write data |
| tmr_cnt | input | 16 | Free-running 16-bit timer value |
| cap_pin | input | 1 | Capture input pin |
| per_cnt | input | 8 | Period timer count |
| per_phase | input | 2 | Period timer prescaler phase |
| per_start | input | 1 | High on the first tick of each period (count 0, phase 0) |
| val_o | output | 16 | Shared capture, compare and duty register |
| irq_o | output | 1 | Sticky interrupt flag |
| out_pin | output | 1 | Registered compare or PWM output pin |

## Verification
The bench builds the unit with its defaults: a 16-bit timer, an 8-bit period count, and edge dividers of 4 and 16. With these values the 16-edge divider completes in about thirty cycles. The modelled period register is kept between 2 and 12, so a full PWM period lasts only a few dozen ticks. This makes zero duty, saturated duty and mid-period duty rewrites cheap to reach many times over. Randomly toggled pins, timer values and mode switches exercise the edge counter clearing and the flag priority rule against a per-cycle reference.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int PH_W = 2;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_CAP = 2'd1,
    MODE_CMP = 2'd2,
    MODE_PWM = 2'd3
  } ccp_mode_e;

  localparam logic [1:0] CAP_FALL = 2'd0;
  localparam logic [1:0] CAP_RISE = 2'd1;
  localparam logic [1:0] CAP_DIVA = 2'd2;

  localparam logic [1:0] ACT_HIGH = 2'd1;
  localparam logic [1:0] ACT_LOW  = 2'd2;

  typedef struct packed {
    logic [PH_W-1:0] dlo;
    logic [1:0]      sub;
    ccp_mode_e       mode;
  } ctrl_t;
endpackage

// File: rtl/ccp_regs.sv
module ccp_regs
  import ccp_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cap_ev,
  input  logic [TMR_W-1:0]  cap_val,
  input  logic              evt,
  output ctrl_t             ctrl_q,
  output logic [TMR_W-1:0]  val_q,
  output logic              flag_q,
  output logic              cfg_chg
);
  localparam int NB = TMR_W / 8;
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NB + 1);

  logic wr_ctrl;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign cfg_chg = wr_ctrl && (wr_data[3:0] != {ctrl_q.sub, ctrl_q.mode});

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.mode <= ccp_mode_e'(wr_data[1:0]);
      ctrl_q.sub  <= wr_data[3:2];
      ctrl_q.dlo  <= wr_data[4 +: PH_W];
    end
  end

  logic [7:0] lane_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam logic [ADDR_W-1:0] A_LANE = ADDR_W'(b + 1);
    always_ff @(posedge clk) begin
      if (rst)
        lane_q[b] <= '0;
      else if (cap_ev)
        lane_q[b] <= cap_val[8*b +: 8];
      else if (wr_en && (wr_addr == A_LANE))
        lane_q[b] <= wr_data;
    end
    assign val_q[8*b +: 8] = lane_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst)
      flag_q <= 1'b0;
    else if (evt)
      flag_q <= 1'b1;
    else if (wr_en && (wr_addr == A_FLAG))
      flag_q <= wr_data[0];
  end
endmodule

// File: rtl/ccp_capture.sv
module ccp_capture
  import ccp_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       cfg_chg,
  input  logic       pin,
  output logic       cap_ev
);
  localparam int CNT_W = $clog2(DIV_B);

  logic             pin_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;
  logic             rise, fall;

  assign rise   = pin && !pin_q;
  assign fall   = !pin && pin_q;
  assign target = (sel == CAP_DIVA) ? CNT_W'(DIV_A - 1) : CNT_W'(DIV_B - 1);

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin;
  end

  always_comb begin
    cap_ev = 1'b0;
    if (en && !cfg_chg) begin
      case (sel)
        CAP_FALL: cap_ev = fall;
        CAP_RISE: cap_ev = rise;
        default:  cap_ev = rise && (cnt_q == target);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en || cfg_chg)
      cnt_q <= '0;
    else if (sel[1] && rise)
      cnt_q <= (cnt_q == target) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm
  import ccp_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PER_W+PH_W-1:0] duty_new,
  input  logic [PER_W-1:0]      per_cnt,
  input  logic [PH_W-1:0]       per_phase,
  input  logic                  per_start,
  input  logic                  cur,
  output logic                  nxt
);
  logic [PER_W+PH_W-1:0] dbuf_q;

  always_ff @(posedge clk) begin
    if (rst)            dbuf_q <= '0;
    else if (per_start) dbuf_q <= duty_new;
  end

  always_comb begin
    if (per_start)
      nxt = |duty_new;
    else if ({per_cnt, per_phase} == dbuf_q)
      nxt = 1'b0;
    else
      nxt = cur;
  end
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int PER_W  = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [TMR_W-1:0]  tmr_cnt,
  input  logic              cap_pin,
  input  logic [PER_W-1:0]  per_cnt,
  input  logic [PH_W-1:0]   per_phase,
  input  logic              per_start,
  output logic [TMR_W-1:0]  val_o,
  output logic              irq_o,
  output logic              out_pin
);
  localparam int DUTY_W = PER_W + PH_W;

  ctrl_t             ctrl_q;
  logic [TMR_W-1:0]  val_q;
  logic              flag_q, cfg_chg, cap_ev, match, pwm_nxt, pin_q;
  logic [1:0]        mode_w, sub_w;
  logic [DUTY_W-1:0] duty_new;

  assign mode_w   = ctrl_q.mode;
  assign sub_w    = ctrl_q.sub;
  assign match    = (mode_w == MODE_CMP) && (tmr_cnt == val_q);
  assign duty_new = {val_q[PER_W-1:0], ctrl_q.dlo};

  ccp_regs #(.TMR_W(TMR_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_ev(cap_ev), .cap_val(tmr_cnt), .evt(cap_ev || match),
    .ctrl_q(ctrl_q), .val_q(val_q), .flag_q(flag_q), .cfg_chg(cfg_chg)
  );

  ccp_capture #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_cap (
    .clk(clk), .rst(rst), .en(mode_w == MODE_CAP), .sel(sub_w),
    .cfg_chg(cfg_chg), .pin(cap_pin), .cap_ev(cap_ev)
  );

  ccp_pwm #(.PER_W(PER_W)) u_pwm (
    .clk(clk), .rst(rst), .duty_new(duty_new), .per_cnt(per_cnt),
    .per_phase(per_phase), .per_start(per_start), .cur(pin_q), .nxt(pwm_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
    end else begin
      case (mode_w)
        MODE_CMP: begin
          if (match) begin
            if (sub_w == ACT_HIGH)     pin_q <= 1'b1;
            else if (sub_w == ACT_LOW) pin_q <= 1'b0;
          end
        end
        MODE_PWM: pin_q <= pwm_nxt;
        default:  pin_q <= 1'b0;
      endcase
    end
  end

  assign val_o   = val_q;
  assign irq_o   = flag_q;
  assign out_pin = pin_q;
endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk #(
  parameter int TMR_W  = 16,
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic [1:0]        sub,
  input logic              cap_ev,
  input logic              match,
  input logic              per_start,
  input logic [DUTY_W-1:0] duty,
  input logic [TMR_W-1:0]  tmr_cnt,
  input logic [TMR_W-1:0]  val_o,
  input logic              irq_o,
  input logic              out_pin
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d === 1'b1)
      assert_reset_R1: assert (val_o == '0 && !irq_o && !out_pin)
        else $error("outputs not cleared after reset");
  end

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    cap_ev |=> (val_o == $past(tmr_cnt)));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    (cap_ev || match) |=> irq_o);

  assert_cmp_high_R6: assert property (@(posedge clk) disable iff (rst)
    (match && sub == 2'd1) |=> out_pin);

  assert_cmp_low_R6: assert property (@(posedge clk) disable iff (rst)
    (match && sub == 2'd2) |=> !out_pin);

  assert_pwm_start_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && per_start && duty != '0) |=> out_pin);

  assert_pwm_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && per_start && duty == '0) |=> !out_pin);

  assert_idle_low_R12: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 || mode == 2'd1) |=> !out_pin);
endmodule

bind ccp_unit ccp_unit_chk #(.TMR_W(TMR_W), .DUTY_W(PER_W + ccp_pkg::PH_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_w), .sub(sub_w), .cap_ev(cap_ev),
  .match(match), .per_start(per_start), .duty(duty_new), .tmr_cnt(tmr_cnt),
  .val_o(val_o), .irq_o(irq_o), .out_pin(out_pin)
);

// File: tb/sim_ccp_unit.sv
module sim_ccp_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] tmr_cnt = '0;
  logic        cap_pin = 1'b0;
  logic [7:0]  per_cnt = '0;
  logic [1:0]  per_phase = '0;
  logic        per_start = 1'b1;
  logic [15:0] val_o;
  logic        irq_o, out_pin;

  always #2 clk = ~clk;

  ccp_unit u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_cnt(tmr_cnt), .cap_pin(cap_pin), .per_cnt(per_cnt), .per_phase(per_phase),
    .per_start(per_start), .val_o(val_o), .irq_o(irq_o), .out_pin(out_pin)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  // reference state
  logic [15:0] m_val = '0;
  logic        m_flag = 1'b0, m_pin = 1'b0, m_pinq = 1'b0;
  logic [5:0]  m_ctrl = '0;
  logic [9:0]  m_dbuf = '0;
  int          m_cnt = 0;
  // period timer model
  int pr = 9, b_cnt = 0, b_ph = 0;
  // PWM high-time window
  bit w_on = 1'b0;
  int w_high = 0, w_duty = 0;

  function automatic int tgt(input logic [1:0] s);
    return (s == 2'd2) ? 3 : 15;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_per();
    per_cnt   = 8'(b_cnt);
    per_phase = 2'(b_ph);
    per_start = (b_cnt == 0) && (b_ph == 0);
  endtask

  task automatic step();
    logic [1:0]  md, sl;
    logic        chg, rise, fall, ev, mt, nflag, npin;
    logic [9:0]  shd, ndb;
    logic [15:0] nval;
    logic [5:0]  nctrl;
    int ncnt, tick, n;
    string wt;
    md   = m_ctrl[1:0];
    sl   = m_ctrl[3:2];
    chg  = wr_en && wr_addr == 2'd0 && wr_data[3:0] != m_ctrl[3:0];
    rise = cap_pin && !m_pinq;
    fall = !cap_pin && m_pinq;
    ev = 1'b0;
    if (md == 2'd1 && !chg) begin
      if (sl == 2'd0)      ev = fall;
      else if (sl == 2'd1) ev = rise;
      else                 ev = rise && (m_cnt == tgt(sl));
    end
    ncnt = m_cnt;
    if (md != 2'd1 || chg) ncnt = 0;
    else if (sl[1] && rise) ncnt = (m_cnt == tgt(sl)) ? 0 : m_cnt + 1;
    mt   = (md == 2'd2) && (tmr_cnt == m_val);
    shd  = {m_val[7:0], m_ctrl[5:4]};
    tick = b_cnt * 4 + b_ph;
    n    = (pr + 1) * 4;
    nval = m_val;
    if (ev) nval = tmr_cnt;
    else if (wr_en && wr_addr == 2'd1) nval[7:0]  = wr_data;
    else if (wr_en && wr_addr == 2'd2) nval[15:8] = wr_data;
    nflag = m_flag;
    if (ev || mt) nflag = 1'b1;
    else if (wr_en && wr_addr == 2'd3) nflag = wr_data[0];
    nctrl = (wr_en && wr_addr == 2'd0) ? wr_data[5:0] : m_ctrl;
    ndb   = per_start ? shd : m_dbuf;
    case (md)
      2'd2:    npin = mt ? ((sl == 2'd1) ? 1'b1 : (sl == 2'd2) ? 1'b0 : m_pin) : m_pin;
      2'd3:    npin = per_start ? (shd != 10'd0) : ((10'(tick) == m_dbuf) ? 1'b0 : m_pin);
      default: npin = 1'b0;
    endcase
    if (rst) begin
      nval = '0; nflag = 1'b0; nctrl = '0; ndb = '0; npin = 1'b0; ncnt = 0;
    end
    @(posedge clk);
    #1;
    m_val = nval; m_flag = nflag; m_ctrl = nctrl; m_dbuf = ndb; m_pin = npin;
    m_cnt = ncnt; m_pinq = rst ? 1'b0 : cap_pin;
    if (tick == 0) begin
      w_on = (md == 2'd3) && !rst;
      w_high = 0;
      w_duty = int'(shd);
    end
    if (m_ctrl[1:0] != 2'd3) w_on = 1'b0;
    if (w_on) begin
      w_high += int'(out_pin);
      if (tick == n - 1) begin
        wt = (w_duty == 0) ? "R9 zero duty" : (w_duty >= n) ? "R11 full duty" : "R8/R10 high time";
        chk(wt, 32'(w_high), 32'((w_duty >= n) ? n : w_duty));
        w_on = 1'b0;
      end
    end
    chk({cur_tag, " val"}, 32'(val_o), 32'(m_val));
    chk({cur_tag, " flag"}, 32'(irq_o), 32'(m_flag));
    chk({cur_tag, " pin"}, 32'(out_pin), 32'(m_pin));
    if (b_ph == 3) begin
      b_ph = 0;
      b_cnt = (b_cnt >= pr) ? 0 : b_cnt + 1;
    end else begin
      b_ph++;
    end
    drive_per();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] t);
    tmr_cnt = t; cap_pin = 1'b1; step();
    cap_pin = 1'b0; step();
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected=completion", 150000);
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    drive_per();
    // R1 reset
    cur_tag = "R1";
    run(3);
    rst = 1'b0;
    step();
    chk("R1 val", 32'(val_o), 32'd0);
    chk("R1 flag", 32'(irq_o), 32'd0);
    chk("R1 pin", 32'(out_pin), 32'd0);

    // R2 byte writes
    cur_tag = "R2";
    wr(2'd1, 8'h34);
    wr(2'd2, 8'h12);
    chk("R2 value bytes", 32'(val_o), 32'h1234);

    // R3 single-edge capture, R7 flag
    cur_tag = "R3";
    wr(2'd0, 8'h05);
    tmr_cnt = 16'hABCD; cap_pin = 1'b1; step();
    chk("R3 rising capture", 32'(val_o), 32'hABCD);
    chk("R7 flag after capture", 32'(irq_o), 32'd1);
    tmr_cnt = 16'h0001; cap_pin = 1'b0; step();
    chk("R3 falling ignored in rising mode", 32'(val_o), 32'hABCD);
    wr(2'd3, 8'h00);
    chk("R7 flag cleared by write", 32'(irq_o), 32'd0);
    wr(2'd0, 8'h01);
    tmr_cnt = 16'h2222; cap_pin = 1'b1; step();
    chk("R3 rising ignored in falling mode", 32'(val_o), 32'hABCD);
    tmr_cnt = 16'h1111; cap_pin = 1'b0; step();
    chk("R3 falling capture", 32'(val_o), 32'h1111);

    // R4 prescaled capture
    cur_tag = "R4";
    wr(2'd0, 8'h09);
    for (int i = 1; i <= 4; i++) begin
      pulse(16'h0100 + 16'(i));
      chk("R4 every 4th", 32'(val_o), (i < 4) ? 32'h1111 : 32'h0104);
    end
    wr(2'd0, 8'h0D);
    for (int i = 1; i <= 16; i++) begin
      pulse(16'h0200 + 16'(i));
      if (i >= 15) chk("R4 every 16th", 32'(val_o), (i < 16) ? 32'h0104 : 32'h0210);
    end

    // R5 config change restarts count
    cur_tag = "R5";
    wr(2'd0, 8'h09);
    pulse(16'h0301);
    pulse(16'h0302);
    wr(2'd0, 8'h0D);
    wr(2'd0, 8'h09);
    for (int i = 1; i <= 4; i++) begin
      pulse(16'h0310 + 16'(i));
      chk("R5 count restarted", 32'(val_o), (i < 4) ? 32'h0210 : 32'h0314);
    end

    // R7 priority and set by write
    cur_tag = "R7";
    wr(2'd0, 8'h05);
    wr(2'd3, 8'h00);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00;
    tmr_cnt = 16'h4444; cap_pin = 1'b1; step();
    wr_en = 1'b0;
    chk("R7 event beats flag write", 32'(irq_o), 32'd1);
    chk("R3 capture with flag write", 32'(val_o), 32'h4444);
    cap_pin = 1'b0; step();
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h01);
    chk("R7 flag set by write", 32'(irq_o), 32'd1);

    // random capture traffic
    cur_tag = "R3/R4/R5/R7";
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 40 == 0) wr(2'd0, 8'h01 | 8'(($urandom % 4) << 2));
      if ($urandom % 15 == 0) wr(2'd3, 8'h00);
      cap_pin = 1'($urandom % 2);
      tmr_cnt = 16'($urandom);
      step();
    end
    cap_pin = 1'b0;

    // R6 compare
    cur_tag = "R6";
    wr(2'd0, 8'h00);
    tmr_cnt = 16'h0000;
    wr(2'd1, 8'h50);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h06);
    tmr_cnt = 16'h0049; step();
    chk("R6 no match pin", 32'(out_pin), 32'd0);
    chk("R7 no match flag", 32'(irq_o), 32'd0);
    tmr_cnt = 16'h0050; step();
    chk("R6 match drives high", 32'(out_pin), 32'd1);
    chk("R7 match sets flag", 32'(irq_o), 32'd1);
    tmr_cnt = 16'h0000;
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h02);
    tmr_cnt = 16'h0050; step();
    chk("R6 keep action", 32'(out_pin), 32'd1);
    chk("R7 match sets flag again", 32'(irq_o), 32'd1);
    tmr_cnt = 16'h0000;
    wr(2'd0, 8'h0A);
    tmr_cnt = 16'h0050; step();
    chk("R6 match drives low", 32'(out_pin), 32'd0);
    tmr_cnt = 16'h0000;
    wr(2'd0, 8'h06);
    tmr_cnt = 16'h0050; step();
    chk("R6 high again", 32'(out_pin), 32'd1);
    tmr_cnt = 16'h0000;

    // R12 idle low
    cur_tag = "R12";
    wr(2'd0, 8'h01);
    step();
    chk("R12 capture mode pin low", 32'(out_pin), 32'd0);

    // random compare traffic
    cur_tag = "R6/R7";
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h06);
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 25 == 0) wr(2'd0, 8'h02 | 8'(($urandom % 4) << 2));
      if ($urandom % 10 == 0) wr(2'd3, 8'h00);
      tmr_cnt = 16'($urandom % 4);
      step();
    end
    wr(2'd0, 8'h00);
    step();
    chk("R12 off mode pin low", 32'(out_pin), 32'd0);

    // R8 PWM, duty 21 of 40
    cur_tag = "R8";
    pr = 9; b_cnt = 0; b_ph = 0; drive_per();
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h1F);
    run(3 * 40);
    // R10 mid-period rewrite to 30
    cur_tag = "R10";
    while (!(b_cnt == 2 && b_ph == 2)) step();
    wr(2'd1, 8'd7);
    wr(2'd0, 8'h2F);
    run(2 * 40);
    // R9 zero duty
    cur_tag = "R9";
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h0F);
    run(2 * 40 + 5);
    chk("R9 pin low", 32'(out_pin), 32'd0);
    // R11 duty equal to and above period
    cur_tag = "R11";
    wr(2'd1, 8'd10);
    run(2 * 40 + 5);
    chk("R11 pin high", 32'(out_pin), 32'd1);
    wr(2'd1, 8'd255);
    wr(2'd0, 8'h3F);
    run(2 * 40);

    // random PWM
    cur_tag = "R8/R10/R11";
    for (int r = 0; r < 14; r++) begin
      wr(2'd0, 8'h00);
      pr = 2 + int'($urandom % 11);
      b_cnt = 0; b_ph = 0; drive_per();
      wr(2'd1, 8'($urandom % (pr + 3)));
      wr(2'd0, 8'h0F | 8'(($urandom % 4) << 4));
      for (int i = 0; i < 4 * (pr + 1) * 4; i++) begin
        if ($urandom % 20 == 0) wr(2'd1, 8'($urandom % (pr + 3)));
        else if ($urandom % 20 == 0) wr(2'd0, 8'h0F | 8'(($urandom % 4) << 4));
        else step();
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule